// File: doc/BRIEF.md
# SPI Command and Register Front End

This block is the serial command front end of a peripheral. An external host talks to it as an SPI slave in mode 0 (chip select active low, data sampled on the rising clock edge, driven after the falling edge). Every transaction starts when chip select falls. The first byte the host sends is a one-byte command. While that byte arrives, the block sends the 8-bit status word it receives from the device core. The bytes that follow the command carry data. They go least significant byte first, and inside each byte the most significant bit goes first.

The commands cover the whole register map, which has 32 addresses. Each register is one to five bytes wide. Register reads use a combinational read port, and register writes go out on a registered byte-wide write port. There are also payload commands, which produce one strobe per byte toward the receive and transmit FIFOs, and single-cycle flush and reuse strobes. The serial pins are sampled with the system clock, which must run well above the serial clock. A mode input marks the device as active. While it is set, register writes are dropped. A feature-enable input gates the two extended payload commands.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After chip select falls, and before the first serial clock, MISO carries status bit 7. Over the first eight clocks, the 8 status bits come out most significant bit first.
- R2: The command byte is taken most significant bit first and decoded as follows. 000aaaaa reads a register, 001aaaaa writes a register, 0x61 reads a receive payload, 0x60 reads the receive width, 0xA0 writes a transmit payload, 0xB0 writes a transmit payload without acknowledge, and 10101ppp writes an acknowledge payload. 0xE1 flushes transmit, 0xE2 flushes receive, 0xE3 reuses the last transmit payload, and 0xFF does nothing.
- R3: A register read returns its bytes on MISO, data byte k being register byte k. Address 0x0A, 0x0B and 0x10 are 5 bytes wide and every other address is 1 byte wide. Any data byte past the width reads 0x00.
- R4: In a register write, each complete data byte k is written to byte k of the register, if k is less than the width. When chip select rises early, the higher bytes keep their values. Bytes past the width are dropped.
- R5: A register write has no effect while dev_active is 1.
- R6: A receive payload read shows rx_head on MISO for each data byte and pulses rx_pop once for each completed byte. A width read returns rx_width in its first data byte and 0x00 after that.
- R7: A transmit payload write pulses tx_wr_stb once for each data byte, with the byte on wr_data. tx_noack is 1 only for 0xB0, and 0xB0 is accepted only while feat_en is 1.
- R8: An acknowledge payload write is accepted only while feat_en is 1 and the pipe field ppp is 0 to 5. It then pulses ack_wr_stb once for each byte, with the pipe on ack_pipe. In any other case it produces no strobe.
- R9: Flush transmit, flush receive and reuse each give exactly one single-cycle pulse on their own output when the command byte completes. At most one strobe output is high in any cycle.
- R10: When chip select rises, the transaction ends. A byte that was only partly shifted in has no effect, and the next transaction starts again at status and command.
- R11: miso_oe is high exactly while chip select is low, delayed by one system clock. MISO is 0 whenever miso_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, idle low |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| dev_active | input | 1 | 1 while the device is active; blocks register writes |
| feat_en | input | 1 | Enables the acknowledge payload write and the no-acknowledge transmit write |
| status_in | input | 8 | Status word sent during the command byte |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for MISO, models the high-impedance state |
| reg_rd_addr | output | 5 | Register read address |
| reg_rd_byte | output | 3 | Byte index within the register being read |
| reg_rd_data | input | 8 | Register read data (combinational) |
| reg_wr_en | output | 1 | Register byte write strobe |
| reg_wr_addr | output | 5 | Register write address |
| reg_wr_byte | output | 3 | Byte index being written |
| wr_data | output | 8 | Data byte for register and payload writes |
| rx_pop | output | 1 | Removes one byte from the receive FIFO |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| rx_width | input | 8 | Width of the top receive payload |
| tx_wr_stb | output | 1 | Transmit payload byte strobe |
| tx_noack | output | 1 | Qualifies tx_wr_stb: packet without acknowledge |
| ack_wr_stb | output | 1 | Acknowledge payload byte strobe |
| ack_pipe | output | 3 | Pipe number for ack_wr_stb |
| flush_tx | output | 1 | Transmit flush pulse |
| flush_rx | output | 1 | Receive flush pulse |
| reuse_tx | output | 1 | Transmit reuse pulse |

## Verification
The assertions assume that the serial pins are synchronous to clk and change far less often than once per clock. They also assume that chip select is held high through reset, and that it never moves in the same cycle as an SCK edge. The stimulus keeps within this. It drives every pin on the falling clock edge and holds each SCK phase for four system clocks. Chip select moves only while SCK is low, with a guard interval on both sides. Commands, register addresses, byte counts, status words and the dev_active state are random. The directed cases cover aborted bytes, early-ended writes, out-of-range pipes and the disabled feature enable.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int MAX_PIPE = 5;
  localparam int WIDE_BYTES = 5;
  localparam logic [4:0] WIDE_REG_0 = 5'h0A;
  localparam logic [4:0] WIDE_REG_1 = 5'h0B;
  localparam logic [4:0] WIDE_REG_2 = 5'h10;

  typedef enum logic [3:0] {
    OP_BAD, OP_RREG, OP_WREG, OP_RPAY, OP_RWID, OP_WPAY,
    OP_WNOACK, OP_WACK, OP_FTX, OP_FRX, OP_REUSE, OP_NOP
  } fe_op_e;

  // Number of bytes held at a register address.
  function automatic logic [2:0] reg_nbytes(input logic [4:0] a);
    if (a == WIDE_REG_0 || a == WIDE_REG_1 || a == WIDE_REG_2)
      return 3'(WIDE_BYTES);
    return 3'd1;
  endfunction

  // Command byte to operation; gated and out-of-range forms map to OP_BAD.
  function automatic fe_op_e decode_op(input logic [7:0] c, input logic feat);
    if (c[7:5] == 3'b000) return OP_RREG;
    if (c[7:5] == 3'b001) return OP_WREG;
    if (c[7:3] == 5'b10101)
      return (feat && 32'(c[2:0]) <= MAX_PIPE) ? OP_WACK : OP_BAD;
    case (c)
      8'h61: return OP_RPAY;
      8'h60: return OP_RWID;
      8'hA0: return OP_WPAY;
      8'hB0: return feat ? OP_WNOACK : OP_BAD;
      8'hE1: return OP_FTX;
      8'hE2: return OP_FRX;
      8'hE3: return OP_REUSE;
      8'hFF: return OP_NOP;
      default: return OP_BAD;
    endcase
  endfunction
endpackage

// File: rtl/spi_fe_edges.sv
module spi_fe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_start,
  output logic cs_active
);
  logic sck_q, csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck;
      csn_q <= csn;
    end
  end

  assign sck_rise  = sck & ~sck_q & ~csn;
  assign sck_fall  = ~sck & sck_q & ~csn;
  assign cs_start  = ~csn & csn_q;
  assign cs_active = ~csn_q;
endmodule

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
  import spi_fe_pkg::*;
(
  input  logic [7:0] cmd_byte,
  input  logic       feat_en,
  output fe_op_e     op,
  output logic [2:0] pipe
);
  assign op   = decode_op(cmd_byte, feat_en);
  assign pipe = cmd_byte[2:0];
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SUB_W  = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  input  logic              dev_active,
  input  logic              feat_en,
  input  logic [7:0]        status_in,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] reg_rd_addr,
  output logic [SUB_W-1:0]  reg_rd_byte,
  input  logic [7:0]        reg_rd_data,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [SUB_W-1:0]  reg_wr_byte,
  output logic [7:0]        wr_data,
  output logic              rx_pop,
  input  logic [7:0]        rx_head,
  input  logic [7:0]        rx_width,
  output logic              tx_wr_stb,
  output logic              tx_noack,
  output logic              ack_wr_stb,
  output logic [2:0]        ack_pipe,
  output logic              flush_tx,
  output logic              flush_rx,
  output logic              reuse_tx
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic sck_rise, sck_fall, cs_start, cs_active;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       sh_in, sh_out, cmd_q;

  // Named internal events
  logic             byte_done, cmd_phase, idx_in_reg;
  logic [7:0]       full_byte, dec_in, rd_byte;
  logic [CNT_W-1:0] data_idx;
  fe_op_e           op;
  logic [2:0]       pipe;

  spi_fe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_start(cs_start), .cs_active(cs_active)
  );

  assign full_byte  = {sh_in[6:0], mosi};
  assign byte_done  = sck_rise && (bit_cnt == 3'd7);
  assign cmd_phase  = (byte_cnt == '0);
  assign data_idx   = byte_cnt - 1'b1;
  assign dec_in     = cmd_phase ? full_byte : cmd_q;
  assign idx_in_reg = data_idx < CNT_W'(reg_nbytes(cmd_q[4:0]));

  spi_fe_decode u_dec (.cmd_byte(dec_in), .feat_en(feat_en), .op(op), .pipe(pipe));

  assign reg_rd_addr = ADDR_W'(cmd_q[4:0]);
  assign reg_rd_byte = data_idx[SUB_W-1:0];

  always_comb begin
    rd_byte = 8'h00;
    case (op)
      OP_RREG: rd_byte = idx_in_reg ? reg_rd_data : 8'h00;
      OP_RPAY: rd_byte = rx_head;
      OP_RWID: rd_byte = (data_idx == '0) ? rx_width : 8'h00;
      default: rd_byte = 8'h00;
    endcase
  end

  assign miso    = cs_active & sh_out[7];
  assign miso_oe = cs_active;

  // Serial shifting and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      sh_in    <= '0;
      sh_out   <= '0;
      cmd_q    <= '0;
    end else if (csn) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else begin
      if (cs_start) sh_out <= status_in;
      if (sck_rise) begin
        sh_in   <= full_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
          if (cmd_phase) cmd_q <= full_byte;
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0 && !cmd_phase) sh_out <= rd_byte;
        else sh_out <= {sh_out[6:0], 1'b0};
      end
    end
  end

  // Registered side-effect strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_byte <= '0;
      wr_data     <= '0;
      rx_pop      <= 1'b0;
      tx_wr_stb   <= 1'b0;
      tx_noack    <= 1'b0;
      ack_wr_stb  <= 1'b0;
      ack_pipe    <= '0;
      flush_tx    <= 1'b0;
      flush_rx    <= 1'b0;
      reuse_tx    <= 1'b0;
    end else begin
      reg_wr_en  <= 1'b0;
      rx_pop     <= 1'b0;
      tx_wr_stb  <= 1'b0;
      tx_noack   <= 1'b0;
      ack_wr_stb <= 1'b0;
      flush_tx   <= 1'b0;
      flush_rx   <= 1'b0;
      reuse_tx   <= 1'b0;
      if (byte_done) begin
        wr_data <= full_byte;
        if (cmd_phase) begin
          flush_tx <= (op == OP_FTX);
          flush_rx <= (op == OP_FRX);
          reuse_tx <= (op == OP_REUSE);
        end else begin
          case (op)
            OP_WREG: begin
              reg_wr_en   <= !dev_active && idx_in_reg;
              reg_wr_addr <= ADDR_W'(cmd_q[4:0]);
              reg_wr_byte <= data_idx[SUB_W-1:0];
            end
            OP_RPAY:   rx_pop <= 1'b1;
            OP_WPAY:   tx_wr_stb <= 1'b1;
            OP_WNOACK: begin
              tx_wr_stb <= 1'b1;
              tx_noack  <= 1'b1;
            end
            OP_WACK: begin
              ack_wr_stb <= 1'b1;
              ack_pipe   <= pipe;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
  import spi_fe_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       csn,
  input logic       dev_active,
  input logic [7:0] status_in,
  input logic       cs_start,
  input logic       miso,
  input logic       miso_oe,
  input logic       reg_wr_en,
  input logic [4:0] reg_wr_addr,
  input logic [2:0] reg_wr_byte,
  input logic       rx_pop,
  input logic       tx_wr_stb,
  input logic       ack_wr_stb,
  input logic [2:0] ack_pipe,
  input logic       flush_tx,
  input logic       flush_rx,
  input logic       reuse_tx
);
  logic any_stb;
  assign any_stb = reg_wr_en | rx_pop | tx_wr_stb | ack_wr_stb | flush_tx | flush_rx | reuse_tx;

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (miso == $past(status_in[7]))); // R1
  AST_WR_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_byte < reg_nbytes(reg_wr_addr))); // R4
  AST_NO_WR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(!dev_active)); // R5
  AST_ACK_PIPE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr_stb |-> (32'(ack_pipe) <= MAX_PIPE)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, rx_pop, tx_wr_stb, ack_wr_stb, flush_tx, flush_rx, reuse_tx})); // R9
  AST_STB_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(!csn)); // R10
  AST_OE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe == $past(!csn)); // R11
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso); // R11
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .dev_active(dev_active),
  .status_in(status_in), .cs_start(cs_start), .miso(miso), .miso_oe(miso_oe),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_byte(reg_wr_byte),
  .rx_pop(rx_pop), .tx_wr_stb(tx_wr_stb), .ack_wr_stb(ack_wr_stb),
  .ack_pipe(ack_pipe), .flush_tx(flush_tx), .flush_rx(flush_rx), .reuse_tx(reuse_tx)
);

// File: tb/spi_cmd_frontend_tb.sv
module spi_cmd_frontend_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic dev_active = 1'b0, feat_en = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic miso, miso_oe;
  logic [4:0] reg_rd_addr, reg_wr_addr;
  logic [2:0] reg_rd_byte, reg_wr_byte, ack_pipe;
  logic [7:0] reg_rd_data, wr_data, rx_head;
  logic [7:0] rx_width = 8'h00;
  logic reg_wr_en, rx_pop, tx_wr_stb, tx_noack, ack_wr_stb, flush_tx, flush_rx, reuse_tx;

  always #5 clk = ~clk;

  spi_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .dev_active(dev_active), .feat_en(feat_en), .status_in(status_in),
    .miso(miso), .miso_oe(miso_oe), .reg_rd_addr(reg_rd_addr), .reg_rd_byte(reg_rd_byte),
    .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_byte(reg_wr_byte), .wr_data(wr_data), .rx_pop(rx_pop), .rx_head(rx_head),
    .rx_width(rx_width), .tx_wr_stb(tx_wr_stb), .tx_noack(tx_noack),
    .ack_wr_stb(ack_wr_stb), .ack_pipe(ack_pipe), .flush_tx(flush_tx),
    .flush_rx(flush_rx), .reuse_tx(reuse_tx)
  );

  // Peripheral models around the block
  logic [7:0] rf [0:31][0:7];
  logic [7:0] exp_rf [0:31][0:7];
  logic [7:0] rx_mem [0:63];
  int rx_rp = 0;
  logic [7:0] tx_log [0:63];
  logic       noack_log [0:63];
  logic [2:0] pipe_log [0:63];
  int tx_n = 0, ack_n = 0, wr_n = 0, ftx_n = 0, frx_n = 0, reuse_n = 0;

  assign reg_rd_data = rf[reg_rd_addr][reg_rd_byte];
  assign rx_head = rx_mem[rx_rp[5:0]];

  always @(posedge clk) if (rst_n) begin
    if (reg_wr_en) begin rf[reg_wr_addr][reg_wr_byte] <= wr_data; wr_n <= wr_n + 1; end
    if (rx_pop) rx_rp <= rx_rp + 1;
    if (tx_wr_stb) begin tx_log[tx_n[5:0]] <= wr_data; noack_log[tx_n[5:0]] <= tx_noack; tx_n <= tx_n + 1; end
    if (ack_wr_stb) begin tx_log[ack_n[5:0]] <= wr_data; pipe_log[ack_n[5:0]] <= ack_pipe; ack_n <= ack_n + 1; end
    if (flush_tx) ftx_n <= ftx_n + 1;
    if (flush_rx) frx_n <= frx_n + 1;
    if (reuse_tx) reuse_n <= reuse_n + 1;
  end

  int vectors = 0, fails = 0;
  logic [7:0] tx_buf [0:15];
  logic [7:0] rx_buf [0:15];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic int exp_width(input logic [4:0] a);
    return (a == 5'h0A || a == 5'h0B || a == 5'h10) ? 5 : 1;
  endfunction

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  // Shifts n whole bytes and then extra_bits more; checks status on byte 0 (R1)
  task automatic xfer(input int n, input int extra_bits = 0);
    logic [7:0] st;
    st = 8'($urandom);
    status_in = st;
    csn = 1'b0;
    half();
    chk("R11 oe while selected", 32'(miso_oe), 32'd1);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = tx_buf[i][b];
        half();
        rx_buf[i][b] = miso;
        sck = 1'b1;
        half();
        sck = 1'b0;
      end
    end
    for (int b = 0; b < extra_bits; b++) begin
      mosi = 1'b1; half(); sck = 1'b1; half(); sck = 1'b0;
    end
    half();
    csn = 1'b1;
    half(); half();
    if (n > 0) chk("R1 status on MISO", 32'(rx_buf[0]), 32'(st));
  endtask

  task automatic do_write(input logic [4:0] a, input int n);
    tx_buf[0] = {3'b001, a};
    for (int i = 1; i <= n; i++) tx_buf[i] = 8'($urandom);
    xfer(n + 1);
    if (!dev_active)
      for (int i = 0; i < n && i < exp_width(a); i++) exp_rf[a][i] = tx_buf[i + 1];
  endtask

  task automatic do_read(input logic [4:0] a, input int n);
    tx_buf[0] = {3'b000, a};
    for (int i = 1; i <= n; i++) tx_buf[i] = 8'hFF;
    xfer(n + 1);
    for (int i = 0; i < n; i++)
      chk("R3 R4 register read byte", 32'(rx_buf[i + 1]),
          32'((i < exp_width(a)) ? exp_rf[a][i] : 8'h00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int w0, t0, a0;
    void'($urandom(32'h5EED_1234));
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 8; b++) begin
        rf[a][b] = 8'(a * 8 + b + 3);
        exp_rf[a][b] = 8'(a * 8 + b + 3);
      end
    for (int i = 0; i < 64; i++) rx_mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    half();

    // Reset state (R11)
    chk("R11 reset oe", 32'(miso_oe), 32'd0);
    chk("R11 reset miso", 32'(miso), 32'd0);
    chk("R9 reset no strobes", 32'(wr_n + tx_n + ftx_n), 32'd0);

    // NOP with several status words (R1, R2)
    for (int k = 0; k < 4; k++) begin tx_buf[0] = 8'hFF; xfer(1); end

    // Full write and read back of a wide register, one byte past it (R3, R4)
    do_write(5'h0A, 5);
    do_read(5'h0A, 6);
    // Early end leaves upper bytes (R4)
    do_write(5'h0B, 2);
    do_read(5'h0B, 5);
    // Narrow register: second byte dropped, reads 0 past width (R3, R4)
    w0 = wr_n;
    do_write(5'h05, 2);
    chk("R4 one write to narrow reg", 32'(wr_n - w0), 32'd1);
    do_read(5'h05, 2);

    // Writes blocked while active (R5)
    dev_active = 1'b1;
    w0 = wr_n;
    do_write(5'h10, 5);
    do_write(5'h03, 1);
    chk("R5 no write strobe when active", 32'(wr_n - w0), 32'd0);
    dev_active = 1'b0;
    do_read(5'h10, 5);
    do_read(5'h03, 1);

    // Aborted partial byte (R10)
    w0 = wr_n;
    tx_buf[0] = 8'h27;
    xfer(1, 4);
    chk("R10 partial byte no write", 32'(wr_n - w0), 32'd0);
    do_read(5'h07, 1);
    tx_buf[0] = 8'hFF; xfer(1);

    // Receive payload read (R6)
    tx_buf[0] = 8'h61;
    for (int i = 1; i <= 5; i++) tx_buf[i] = 8'h00;
    xfer(6);
    for (int i = 0; i < 5; i++) chk("R6 payload byte", 32'(rx_buf[i + 1]), 32'(rx_mem[i]));
    chk("R6 pop count", 32'(rx_rp), 32'd5);
    rx_width = 8'h1C;
    tx_buf[0] = 8'h60; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    xfer(3);
    chk("R6 width byte", 32'(rx_buf[1]), 32'h1C);
    chk("R6 width trailing zero", 32'(rx_buf[2]), 32'h00);
    chk("R6 width read no pop", 32'(rx_rp), 32'd5);

    // Transmit writes (R7)
    t0 = tx_n;
    tx_buf[0] = 8'hA0;
    for (int i = 1; i <= 4; i++) tx_buf[i] = 8'($urandom);
    xfer(5);
    chk("R7 tx count", 32'(tx_n - t0), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R7 tx data", 32'(tx_log[t0 + i]), 32'(tx_buf[i + 1]));
      chk("R7 tx noack clear", 32'(noack_log[t0 + i]), 32'd0);
    end
    feat_en = 1'b1;
    t0 = tx_n;
    tx_buf[0] = 8'hB0;
    xfer(4);
    chk("R7 noack count", 32'(tx_n - t0), 32'd3);
    chk("R7 noack flag", 32'(noack_log[t0 + 2]), 32'd1);
    chk("R7 noack data", 32'(tx_log[t0 + 2]), 32'(tx_buf[3]));
    feat_en = 1'b0;
    t0 = tx_n;
    xfer(4);
    chk("R7 noack gated by feature", 32'(tx_n - t0), 32'd0);

    // Acknowledge payload writes (R8); ack_n is the write index, so reset tx_log index use
    feat_en = 1'b1;
    a0 = ack_n;
    tx_buf[0] = 8'hAB; tx_buf[1] = 8'h5A; tx_buf[2] = 8'hC3;
    xfer(3);
    chk("R8 ack count", 32'(ack_n - a0), 32'd2);
    chk("R8 ack pipe", 32'(pipe_log[a0 + 1]), 32'd3);
    chk("R8 ack data", 32'(tx_log[a0 + 1]), 32'hC3);
    a0 = ack_n;
    tx_buf[0] = 8'hAE;
    xfer(3);
    chk("R8 pipe 6 rejected", 32'(ack_n - a0), 32'd0);
    feat_en = 1'b0;
    tx_buf[0] = 8'hA9;
    xfer(3);
    chk("R8 feature off rejected", 32'(ack_n - a0), 32'd0);

    // Flush and reuse (R9, R2)
    tx_buf[0] = 8'hE1; xfer(1);
    tx_buf[0] = 8'hE2; xfer(1);
    tx_buf[0] = 8'hE3; xfer(1);
    chk("R9 flush tx once", 32'(ftx_n), 32'd1);
    chk("R9 flush rx once", 32'(frx_n), 32'd1);
    chk("R9 reuse once", 32'(reuse_n), 32'd1);

    // Constrained random register traffic (R3, R4, R5)
    for (int k = 0; k < 40; k++) begin
      logic [4:0] a;
      a = 5'($urandom_range(31, 0));
      dev_active = ($urandom_range(7, 0) == 0);
      do_write(a, $urandom_range(6, 1));
      dev_active = 1'b0;
      do_read(a, 6);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule